// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host, through a small window of 64-bit memory-mapped registers, access to a separate 32-bit register space. That register space sits behind a request/acknowledge bus. The host writes one command word. The command word carries an operation code, a target register address and, for a store, the data to store. The bridge turns that word into exactly one transaction on the downstream bus. It holds the request until the far side acknowledges, however many cycles that takes.

Completion is reported in a status word. The status word carries a valid flag and, for a load, the data returned. The host polls the status word until the flag is set. A transaction normally completes within one or two polls. While a transaction is outstanding, further commands are dropped, so the pending transaction cannot be disturbed.

A read-only identity word describes the bridge's geometry to software. It gives the data width, the register address width, the address stride and a build identifier.

Top module: `ind_reg_bridge`

## Requirements
- R1: Host byte offsets are 0x08 (identity word), 0x10 (command) and 0x18 (status). Every other offset, and the command offset itself, reads as zero. `h_rvalid` is high, and `h_rdata` carries the selected word, in the cycle after the cycle in which `h_rd_en` was sampled high.
- R2: The command word has three fields: bits 63:62 are the opcode, bits 44:32 are the register address, and bits 31:0 are the store data. A command with opcode 1 (load) or 2 (store), written while no transaction is outstanding, raises `d_req` in the next cycle. With it, `d_addr` equals bits 44:32, `d_we` is 1 for a store and 0 for a load, and `d_wdata` is bits 31:0 for a store and zero for a load.
- R3: A command with opcode 0 or opcode 3 starts no transaction and leaves the status word unchanged.
- R4: `d_req`, `d_we`, `d_addr` and `d_wdata` stay constant until `d_ack` is sampled high while `d_req` is high. `d_req` is low in the following cycle. `d_ack` while `d_req` is low has no effect.
- R5: The status word holds returned data in bits 31:0 and the valid flag in bit 32. One cycle after the acknowledge, the flag is 1 and, for a load, bits 31:0 equal `d_rdata` as sampled with the acknowledge.
- R6: After a store completes, status bits 31:0 are zero.
- R7: An accepted command clears the valid flag in the cycle `d_req` rises. The flag stays 0 for as long as `d_req` is high.
- R8: A command written while a transaction is outstanding (including the acknowledge cycle) is dropped. The pending transaction and its result are unaffected.
- R9: Synchronous active-high reset drops `d_req`, clears the valid flag and the status data, and returns the bridge to idle, even in the middle of a transaction.
- R10: The identity word holds three widths and an identifier, one per field. Bits 7:0 hold the data width (32). Bits 15:8 hold the register address width (13). Bits 23:16 hold the address stride in bytes (4). Bits 47:32 hold the `BRIDGE_ID` parameter (default 0x1D5E). All other bits are zero. The register address is a byte address passed to `d_addr` unchanged.
- R11: Host writes to any offset other than the command offset start nothing and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | HOST_AW (8) | Host byte offset |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, registered |
| h_rvalid | output | 1 | Host read data valid, one cycle after the read strobe |
| d_req | output | 1 | Downstream request, held until acknowledged |
| d_we | output | 1 | Downstream direction: 1 = store |
| d_addr | output | REG_AW (13) | Downstream register byte address |
| d_wdata | output | DATA_W (32) | Downstream store data |
| d_ack | input | 1 | Downstream acknowledge |
| d_rdata | input | DATA_W (32) | Downstream load data, valid with the acknowledge |

## Verification
A command written in cycle N shows up as `d_req` and its fields after one register stage, in cycle N+1. An acknowledge sampled in cycle M makes the status flag and data visible from cycle M+1. A host read in cycle K returns its word in cycle K+1, and that word reflects the state before any update made in cycle K. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge with those inputs. It then compares every output on the next falling edge, so each comparison lands in exactly the cycle the result is due. The downstream responder acknowledges after a latency chosen per test. The responder can also raise a stray acknowledge while the bus is idle. Together these exercise zero-wait, multi-cycle, busy-overlap and mid-transaction-reset cases.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int WORD_W         = 64;
  localparam int CMD_ADDR_LSB   = 32;
  localparam int CMD_OP_LSB     = 62;
  localparam int STAT_VALID_BIT = 32;
  localparam int REG_STRIDE     = 4;

  localparam logic [7:0] OFF_IDENT = 8'h08;
  localparam logic [7:0] OFF_CMD   = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h18;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/irb_cmd_decode.sv
module irb_cmd_decode
  import irb_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 13
) (
  input  logic               h_wr_en,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [WORD_W-1:0]  h_wdata,
  input  logic               busy,
  output logic               launch,
  output logic               launch_we,
  output logic [REG_AW-1:0]  launch_addr,
  output logic [DATA_W-1:0]  launch_wdata
);
  op_e  op;
  logic cmd_hit;

  assign op      = op_e'(h_wdata[CMD_OP_LSB +: 2]);
  assign cmd_hit = h_wr_en && (h_addr == HOST_AW'(OFF_CMD));

  always_comb begin
    launch       = cmd_hit && !busy && ((op == OP_LOAD) || (op == OP_STORE));
    launch_we    = (op == OP_STORE);
    launch_addr  = h_wdata[CMD_ADDR_LSB +: REG_AW];
    launch_wdata = launch_we ? h_wdata[DATA_W-1:0] : '0;
  end

  // Bits between the address field and the opcode carry nothing.
  logic unused_hi;
  assign unused_hi = ^h_wdata[CMD_OP_LSB-1:CMD_ADDR_LSB+REG_AW];

  generate
    if (DATA_W < CMD_ADDR_LSB) begin : g_lo_gap
      logic unused_lo;
      assign unused_lo = ^h_wdata[CMD_ADDR_LSB-1:DATA_W];
    end
  endgenerate
endmodule

// File: rtl/irb_txn_engine.sv
module irb_txn_engine #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [REG_AW-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_wdata,
  input  logic              d_ack,
  input  logic [DATA_W-1:0] d_rdata,
  output logic              d_req,
  output logic              d_we,
  output logic [REG_AW-1:0] d_addr,
  output logic [DATA_W-1:0] d_wdata,
  output logic              stat_valid,
  output logic [DATA_W-1:0] stat_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      d_req      <= 1'b0;
      d_we       <= 1'b0;
      d_addr     <= '0;
      d_wdata    <= '0;
      stat_valid <= 1'b0;
      stat_data  <= '0;
    end else if (d_req) begin
      // Outstanding: fields hold, only the acknowledge can end it.
      if (d_ack) begin
        d_req      <= 1'b0;
        stat_valid <= 1'b1;
        stat_data  <= d_we ? '0 : d_rdata;
      end
    end else if (launch) begin
      d_req      <= 1'b1;
      d_we       <= launch_we;
      d_addr     <= launch_addr;
      d_wdata    <= launch_wdata;
      stat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irb_host_readback.sv
module irb_host_readback
  import irb_pkg::*;
#(
  parameter int          HOST_AW   = 8,
  parameter int          DATA_W    = 32,
  parameter int          REG_AW    = 13,
  parameter logic [15:0] BRIDGE_ID = 16'h1D5E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_rd_en,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic               stat_valid,
  input  logic [DATA_W-1:0]  stat_data,
  output logic               h_rvalid,
  output logic [WORD_W-1:0]  h_rdata
);
  logic [WORD_W-1:0] ident_word;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    ident_word        = '0;
    ident_word[7:0]   = 8'(DATA_W);
    ident_word[15:8]  = 8'(REG_AW);
    ident_word[23:16] = 8'(REG_STRIDE);
    ident_word[47:32] = BRIDGE_ID;

    stat_word                 = '0;
    stat_word[DATA_W-1:0]     = stat_data;
    stat_word[STAT_VALID_BIT] = stat_valid;

    case (h_addr)
      HOST_AW'(OFF_IDENT): sel_word = ident_word;
      HOST_AW'(OFF_STAT):  sel_word = stat_word;
      default:             sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= h_rd_en;
      if (h_rd_en) h_rdata <= sel_word;
    end
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import irb_pkg::*;
#(
  parameter int          HOST_AW   = 8,
  parameter int          DATA_W    = 32,
  parameter int          REG_AW    = 13,
  parameter logic [15:0] BRIDGE_ID = 16'h1D5E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_wr_en,
  input  logic               h_rd_en,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [63:0]        h_wdata,
  output logic [63:0]        h_rdata,
  output logic               h_rvalid,
  output logic               d_req,
  output logic               d_we,
  output logic [REG_AW-1:0]  d_addr,
  output logic [DATA_W-1:0]  d_wdata,
  input  logic               d_ack,
  input  logic [DATA_W-1:0]  d_rdata
);
  logic              launch;
  logic              launch_we;
  logic [REG_AW-1:0] launch_addr;
  logic [DATA_W-1:0] launch_wdata;
  logic              stat_valid;
  logic [DATA_W-1:0] stat_data;

  irb_cmd_decode #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_decode (
    .h_wr_en      (h_wr_en),
    .h_addr       (h_addr),
    .h_wdata      (h_wdata),
    .busy         (d_req),
    .launch       (launch),
    .launch_we    (launch_we),
    .launch_addr  (launch_addr),
    .launch_wdata (launch_wdata)
  );

  irb_txn_engine #(
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_engine (
    .clk          (clk),
    .rst          (rst),
    .launch       (launch),
    .launch_we    (launch_we),
    .launch_addr  (launch_addr),
    .launch_wdata (launch_wdata),
    .d_ack        (d_ack),
    .d_rdata      (d_rdata),
    .d_req        (d_req),
    .d_we         (d_we),
    .d_addr       (d_addr),
    .d_wdata      (d_wdata),
    .stat_valid   (stat_valid),
    .stat_data    (stat_data)
  );

  irb_host_readback #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .REG_AW(REG_AW), .BRIDGE_ID(BRIDGE_ID)
  ) u_readback (
    .clk        (clk),
    .rst        (rst),
    .h_rd_en    (h_rd_en),
    .h_addr     (h_addr),
    .stat_valid (stat_valid),
    .stat_data  (stat_data),
    .h_rvalid   (h_rvalid),
    .h_rdata    (h_rdata)
  );
endmodule

// File: rtl/irb_checker.sv
module irb_checker
  import irb_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               h_wr_en,
  input logic               h_rd_en,
  input logic [HOST_AW-1:0] h_addr,
  input logic [1:0]         cmd_op,
  input logic               h_rvalid,
  input logic               d_req,
  input logic               d_ack,
  input logic               d_we,
  input logic [REG_AW-1:0]  d_addr,
  input logic [DATA_W-1:0]  d_wdata,
  input logic               stat_valid,
  input logic [DATA_W-1:0]  stat_data
);
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    h_rd_en |=> h_rvalid);

  assert_no_spurious_rvalid_R1: assert property (@(posedge clk) disable iff (rst)
    !h_rd_en |=> !h_rvalid);

  assert_nop_no_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (h_wr_en && (h_addr == HOST_AW'(OFF_CMD)) && !d_req &&
     ((cmd_op == 2'd0) || (cmd_op == 2'd3))) |=> !d_req);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_ack) |=> (d_req && $stable(d_we) && $stable(d_addr) && $stable(d_wdata)));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (d_req && d_ack) |=> !d_req);

  assert_idle_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!d_req && !h_wr_en) |=> ($stable(stat_valid) && $stable(stat_data)));

  assert_valid_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (d_req && d_ack) |=> stat_valid);

  assert_store_zero_data_R6: assert property (@(posedge clk) disable iff (rst)
    (d_req && d_ack && d_we) |=> (stat_data == '0));

  assert_valid_low_busy_R7: assert property (@(posedge clk) disable iff (rst)
    d_req |-> !stat_valid);

  assert_busy_cmd_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_ack && h_wr_en) |=> (d_req && $stable(d_addr) && $stable(d_we)));

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!d_req && !stat_valid && (stat_data == '0)));
endmodule

bind ind_reg_bridge irb_checker #(
  .HOST_AW(HOST_AW), .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_irb_checker (
  .clk        (clk),
  .rst        (rst),
  .h_wr_en    (h_wr_en),
  .h_rd_en    (h_rd_en),
  .h_addr     (h_addr),
  .cmd_op     (h_wdata[63:62]),
  .h_rvalid   (h_rvalid),
  .d_req      (d_req),
  .d_ack      (d_ack),
  .d_we       (d_we),
  .d_addr     (d_addr),
  .d_wdata    (d_wdata),
  .stat_valid (stat_valid),
  .stat_data  (stat_data)
);

// File: tb/test_ind_reg_bridge.sv
module test_ind_reg_bridge;
  localparam logic [63:0] IDENT_EXP = 64'h0000_1D5E_0004_0D20;

  logic        clk, rst;
  logic        h_wr_en, h_rd_en;
  logic [7:0]  h_addr;
  logic [63:0] h_wdata;
  logic [63:0] h_rdata;
  logic        h_rvalid;
  logic        d_req, d_we, d_ack;
  logic [12:0] d_addr;
  logic [31:0] d_wdata, d_rdata;

  int compared = 0;
  int mismatched = 0;

  // responder controls and observations
  int          ack_lat = 0;
  logic        force_ack = 1'b0;
  int          txn_cnt = 0;
  logic        last_we;
  logic [12:0] last_addr;
  logic [31:0] last_wdata;

  // behavioural model state
  logic        m_busy = 0, m_we = 0, m_valid = 0, m_rvalid = 0;
  logic [12:0] m_addr = '0;
  logic [31:0] m_wdata = '0, m_sdata = '0;
  logic [63:0] m_rdata = '0;

  ind_reg_bridge i_ind_reg_bridge (
    .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .d_req(d_req),
    .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_ack(d_ack), .d_rdata(d_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] op, input logic [12:0] a,
                                     input logic [31:0] d);
    return {op, 17'h0, a, d};
  endfunction

  function automatic logic [31:0] resp_data(input logic [12:0] a);
    return 32'hA5A5_0000 | {19'h0, a};
  endfunction

  // Reference model: advances on the rising edge from the inputs applied before it.
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_we <= 0; m_addr <= '0; m_wdata <= '0;
      m_valid <= 0; m_sdata <= '0; m_rvalid <= 0; m_rdata <= '0;
    end else begin
      m_rvalid <= h_rd_en;
      if (h_rd_en)
        m_rdata <= (h_addr == 8'h08) ? IDENT_EXP :
                   (h_addr == 8'h18) ? {31'h0, m_valid, m_sdata} : 64'h0;
      if (m_busy) begin
        if (d_ack) begin
          m_busy <= 0; m_valid <= 1;
          m_sdata <= m_we ? 32'h0 : d_rdata;
        end
      end else if (h_wr_en && h_addr == 8'h10 &&
                   (h_wdata[63:62] == 2'd1 || h_wdata[63:62] == 2'd2)) begin
        m_busy  <= 1; m_valid <= 0;
        m_we    <= (h_wdata[63:62] == 2'd2);
        m_addr  <= h_wdata[44:32];
        m_wdata <= (h_wdata[63:62] == 2'd2) ? h_wdata[31:0] : 32'h0;
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    chk("R2 d_req", {63'h0, d_req}, {63'h0, m_busy});
    chk("R1 h_rvalid", {63'h0, h_rvalid}, {63'h0, m_rvalid});
    chk("R1 h_rdata", h_rdata, m_rdata);
    if (m_busy) begin
      chk("R4 d_we", {63'h0, d_we}, {63'h0, m_we});
      chk("R4 d_addr", {51'h0, d_addr}, {51'h0, m_addr});
      chk("R4 d_wdata", {32'h0, d_wdata}, {32'h0, m_wdata});
    end
  end

  // Downstream responder.
  initial begin
    int cnt;
    cnt = 0; d_ack = 0; d_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        cnt = 0; d_ack = 0;
      end else if (d_req) begin
        if (cnt == ack_lat) begin
          d_ack = 1; d_rdata = resp_data(d_addr); txn_cnt++;
          last_we = d_we; last_addr = d_addr; last_wdata = d_wdata; cnt = 0;
        end else begin
          d_ack = 0; cnt++;
        end
      end else begin
        d_ack = force_ack; d_rdata = 32'hFFFF_FFFF; cnt = 0;
      end
    end
  end

  task automatic host_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); h_wr_en = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr_en = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [63:0] q);
    @(negedge clk); h_rd_en = 1; h_addr = a;
    @(negedge clk); h_rd_en = 0; q = h_rdata;
  endtask

  task automatic poll_stat(output logic [63:0] q);
    q = '0;
    for (int i = 0; i < 40; i++) begin
      host_read(8'h18, q);
      if (q[32]) break;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] q, prev;
    int t0;
    rst = 1; h_wr_en = 0; h_rd_en = 0; h_addr = '0; h_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R9: reset state
    chk("R9 d_req after reset", {63'h0, d_req}, 64'h0);
    host_read(8'h18, q);
    chk("R9 status after reset", q, 64'h0);

    // R10 identity word, R1 map
    host_read(8'h08, q);
    chk("R10 identity word", q, IDENT_EXP);
    host_read(8'h00, q);
    chk("R1 offset 0x00 reads zero", q, 64'h0);
    host_read(8'h10, q);
    chk("R1 command offset reads zero", q, 64'h0);
    host_read(8'h20, q);
    chk("R1 offset 0x20 reads zero", q, 64'h0);

    // R2, R6: store with latency 2
    ack_lat = 2;
    host_write(8'h10, mk(2'd2, 13'h1004, 32'hDEAD_BEEF));
    poll_stat(q);
    chk("R6 store status", q, 64'h0000_0001_0000_0000);
    chk("R2 store direction", {63'h0, last_we}, 64'h1);
    chk("R2 store address", {51'h0, last_addr}, 64'h1004);
    chk("R2 store data", {32'h0, last_wdata}, 64'hDEAD_BEEF);

    // R5: load with zero latency
    ack_lat = 0;
    host_write(8'h10, mk(2'd1, 13'h1020, 32'h1234_5678));
    poll_stat(q);
    chk("R5 load status", q, {31'h0, 1'b1, resp_data(13'h1020)});
    chk("R2 load wdata zero", {32'h0, last_wdata}, 64'h0);
    prev = q;

    // R3: opcode 0 and 3
    t0 = txn_cnt;
    host_write(8'h10, mk(2'd0, 13'h0040, 32'h1));
    host_write(8'h10, mk(2'd3, 13'h0044, 32'h2));
    repeat (3) @(negedge clk);
    host_read(8'h18, q);
    chk("R3 status unchanged", q, prev);
    chk("R3 no transaction", txn_cnt - t0, 0);

    // R11: writes to other offsets
    host_write(8'h08, mk(2'd1, 13'h0048, 32'h3));
    host_write(8'h18, mk(2'd2, 13'h004C, 32'h4));
    repeat (3) @(negedge clk);
    host_read(8'h18, q);
    chk("R11 status unchanged", q, prev);
    chk("R11 no transaction", txn_cnt - t0, 0);

    // R4: stray acknowledge while idle
    force_ack = 1;
    repeat (3) @(negedge clk);
    force_ack = 0;
    host_read(8'h18, q);
    chk("R4 stray ack ignored", q, prev);

    // R7, R8: busy overlap
    ack_lat = 5; t0 = txn_cnt;
    host_write(8'h10, mk(2'd1, 13'h0100, 32'h0));
    host_write(8'h10, mk(2'd2, 13'h0200, 32'hCAFE_F00D));
    host_read(8'h18, q);
    chk("R7 valid low while busy", {63'h0, q[32]}, 64'h0);
    poll_stat(q);
    chk("R8 pending result intact", q, {31'h0, 1'b1, resp_data(13'h0100)});
    chk("R8 single transaction", txn_cnt - t0, 1);
    chk("R8 pending address", {51'h0, last_addr}, 64'h0100);

    // R2: extreme address, junk in spare bits
    ack_lat = 1;
    host_write(8'h10, {2'b01, 17'h1FFFF, 13'h1FFC, 32'hFFFF_FFFF});
    poll_stat(q);
    chk("R2 top address", {51'h0, last_addr}, 64'h1FFC);
    chk("R2 load ignores data field", {32'h0, last_wdata}, 64'h0);
    chk("R5 top address data", q, {31'h0, 1'b1, resp_data(13'h1FFC)});

    // R9: reset mid-transaction
    ack_lat = 10;
    host_write(8'h10, mk(2'd2, 13'h0300, 32'h5555_AAAA));
    repeat (2) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R9 d_req dropped by reset", {63'h0, d_req}, 64'h0);
    host_read(8'h18, q);
    chk("R9 status cleared by reset", q, 64'h0);
    repeat (12) @(negedge clk);
    chk("R9 stays idle", {63'h0, d_req}, 64'h0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule